// File: doc/BRIEF.md
# Shared Converter Conversion Scheduler

This block decides the order of conversions on one converter that two kinds of request share. A standard conversion starts when a start bit goes from 0 to 1. It runs in one of four modes: one channel once, a descending scan, or either of these repeated for as long as the start bit stays high. An injected conversion converts one separately chosen channel once and has higher priority. It is requested by a software request pulse or by a hardware trigger pulse, for example from a compare unit.

Each request is latched. Whenever the converter is free, the scheduler picks the next conversion by fixed priority: a waiting injection first, then a newly started standard sequence, then the next channel of a sequence already running. The converter is a fixed-latency stub with a start, channel and busy interface. A conversion in progress is never cut short. Each kind of conversion has its own one-cycle completion pulse, which carries the channel that was converted.

The scheduler runs through three named states. IDLE means the converter is free and a launch is chosen. STD_RUN means a standard channel is converting. INJ_RUN means an injected channel is converting. The transitions are as follows:
- IDLE goes to INJ_RUN on a launch-injection.
- IDLE goes to STD_RUN on a launch-new-sequence or a launch-next-channel.
- STD_RUN and INJ_RUN each return to IDLE on conversion-done.

Top module: `conv_sched`

## Requirements
- R1: After reset, cnv_start, cnv_busy, std_done, inj_done and inj_pending are all 0.
- R2: A standard sequence is requested only by a 0-to-1 change of std_start. Holding std_start high in a non-continuous mode starts nothing further.
- R3: In single mode (std_mode = 2'b00), exactly one conversion of the selected channel runs, and it gives one std_done pulse carrying that channel.
- R4: With scan enabled (std_mode bit 0 = 1), channels are converted from the selected channel down to channel 0, one std_done per channel, in descending order.
- R5: With continuous enabled (std_mode bit 1 = 1), the sequence repeats while std_start is high when a sequence ends. It stops when std_start is low at the end of a conversion.
- R6: cnv_start is a one-cycle launch in a cycle where the converter is not busy. cnv_busy is then high for exactly LAT cycles, and the done pulse falls in the last of them.
- R7: Either inj_sw_req or inj_hw_trig sets inj_pending one cycle later. inj_pending clears when the injection is launched, and a pending injection is launched in any cycle the converter is free.
- R8: If an injection request and a standard start arrive in the same cycle, the injection is converted first and the standard sequence follows.
- R9: A standard start that arrives during an injected conversion waits until the injection completes, then runs.
- R10: An injection requested during a standard sequence runs after the channel being converted finishes. The sequence then resumes with its next channel.
- R11: A request that arrives in the same cycle its predecessor is launched stays pending and is served afterwards, so injections are never blocked.
- R12: A new standard start during a running sequence replaces that sequence once the current conversion ends.
- R13: std_done and inj_done are one-cycle pulses, are never high together, and are high only while the converter is busy. std_done_chan and inj_done_chan give the converted channel during their pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_start | input | 1 | Standard start bit; a rising edge requests a sequence, a high level keeps continuous modes going |
| std_mode | input | 2 | Bit 0 scan, bit 1 continuous |
| std_chan | input | CH_W | First channel of the standard sequence |
| inj_sw_req | input | 1 | Software injection request pulse |
| inj_hw_trig | input | 1 | Hardware injection trigger pulse |
| inj_chan | input | CH_W | Channel for the injection, captured with the request |
| cnv_start | output | 1 | Converter launch pulse |
| cnv_chan | output | CH_W | Channel being launched or converted |
| cnv_busy | output | 1 | Converter busy |
| std_done | output | 1 | Standard conversion complete |
| std_done_chan | output | CH_W | Channel of the completed standard conversion |
| inj_done | output | 1 | Injected conversion complete |
| inj_done_chan | output | CH_W | Channel of the completed injected conversion |
| inj_pending | output | 1 | Injection request waiting |

## Verification
The assertions check these rules on every cycle:
- no launch while the converter is busy;
- a busy run lasts exactly LAT cycles;
- the done pulses are exclusive, single-cycle and fall inside busy;
- a pending injection is launched as soon as the converter is free.

The ordering between the two kinds of conversion can only be shown by the bench's scenarios, which compare the logged sequence of done pulses against the expected order. This covers coincident requests, a start during an injection, an injection in the middle of a scan, back-to-back triggers, a restart and continuous stopping.

// File: rtl/conv_sched_pkg.sv
`timescale 1ns/1ps
package conv_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STD  = 2'd1,
        ST_INJ  = 2'd2
    } sched_state_e;

    typedef struct packed {
        logic cont;
        logic scan;
    } std_mode_t;

endpackage

// File: rtl/cs_req_capture.sv
`timescale 1ns/1ps
module cs_req_capture
    import conv_sched_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            std_start,
    input  logic [1:0]      std_mode,
    input  logic [CH_W-1:0] std_chan,
    input  logic            inj_sw_req,
    input  logic            inj_hw_trig,
    input  logic [CH_W-1:0] inj_chan,
    input  logic            std_accept,
    input  logic            inj_accept,
    output logic            std_pend,
    output logic [CH_W-1:0] std_pend_chan,
    output std_mode_t       std_pend_mode,
    output logic            inj_pend,
    output logic [CH_W-1:0] inj_pend_chan
);

    logic start_q;
    logic start_rise;
    logic inj_set;

    assign start_rise = std_start & ~start_q;
    assign inj_set    = inj_sw_req | inj_hw_trig;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q       <= 1'b0;
            std_pend      <= 1'b0;
            std_pend_chan <= '0;
            std_pend_mode <= '0;
            inj_pend      <= 1'b0;
            inj_pend_chan <= '0;
        end else begin
            start_q  <= std_start;
            // a new edge wins over the acceptance of the previous one
            std_pend <= (std_pend & ~std_accept) | start_rise;
            if (start_rise) begin
                std_pend_chan <= std_chan;
                std_pend_mode <= std_mode_t'(std_mode);
            end
            // a new trigger wins over acceptance: requests never get lost
            inj_pend <= (inj_pend & ~inj_accept) | inj_set;
            if (inj_set) begin
                inj_pend_chan <= inj_chan;
            end
        end
    end

endmodule

// File: rtl/cs_sequencer.sv
`timescale 1ns/1ps
module cs_sequencer
    import conv_sched_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CH_W-1:0] load_chan,
    input  std_mode_t       load_mode,
    input  logic            step,
    input  logic            keep_going,
    output logic            seq_active,
    output logic [CH_W-1:0] seq_chan
);

    logic [CH_W-1:0] base_chan;
    std_mode_t       mode_q;
    logic            at_floor;

    assign at_floor = (seq_chan == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_active <= 1'b0;
            seq_chan   <= '0;
            base_chan  <= '0;
            mode_q     <= '0;
        end else if (load) begin
            seq_active <= 1'b1;
            seq_chan   <= load_chan;
            base_chan  <= load_chan;
            mode_q     <= load_mode;
        end else if (step) begin
            if (mode_q.scan && !at_floor) begin
                seq_chan <= seq_chan - 1'b1;
            end else if (mode_q.cont && keep_going) begin
                if (mode_q.scan) begin
                    seq_chan <= base_chan;
                end
            end else begin
                seq_active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cs_conv_stub.sv
`timescale 1ns/1ps
module cs_conv_stub #(
    parameter int CH_W = 4,
    parameter int LAT  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CH_W-1:0] chan,
    output logic            busy,
    output logic            done,
    output logic [CH_W-1:0] cur_chan
);

    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            cur_chan <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            cnt      <= CNT_W'(LAT - 1);
            cur_chan <= chan;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/cs_fsm.sv
`timescale 1ns/1ps
module cs_fsm
    import conv_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inj_pend,
    input  logic std_pend,
    input  logic seq_active,
    input  logic cnv_done,
    output logic inj_accept,
    output logic std_accept,
    output logic seq_launch,
    output logic cnv_start,
    output logic std_done,
    output logic inj_done
);

    sched_state_e state_q;
    sched_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (inj_pend) begin
                    state_d = ST_INJ;
                end else if (std_pend || seq_active) begin
                    state_d = ST_STD;
                end
            end
            ST_STD: if (cnv_done) state_d = ST_IDLE;
            ST_INJ: if (cnv_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        inj_accept = 1'b0;
        std_accept = 1'b0;
        seq_launch = 1'b0;
        std_done   = 1'b0;
        inj_done   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                inj_accept = inj_pend;
                std_accept = !inj_pend && std_pend;
                seq_launch = !inj_pend && !std_pend && seq_active;
            end
            ST_STD:  std_done = cnv_done;
            ST_INJ:  inj_done = cnv_done;
            default: ;
        endcase
        cnv_start = inj_accept | std_accept | seq_launch;
    end

endmodule

// File: rtl/conv_sched.sv
`timescale 1ns/1ps
module conv_sched
    import conv_sched_pkg::*;
#(
    parameter int CH_W = 4,
    parameter int LAT  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            std_start,
    input  logic [1:0]      std_mode,
    input  logic [CH_W-1:0] std_chan,
    input  logic            inj_sw_req,
    input  logic            inj_hw_trig,
    input  logic [CH_W-1:0] inj_chan,
    output logic            cnv_start,
    output logic [CH_W-1:0] cnv_chan,
    output logic            cnv_busy,
    output logic            std_done,
    output logic [CH_W-1:0] std_done_chan,
    output logic            inj_done,
    output logic [CH_W-1:0] inj_done_chan,
    output logic            inj_pending
);

    logic            std_pend;
    logic [CH_W-1:0] std_pend_chan;
    std_mode_t       std_pend_mode;
    logic [CH_W-1:0] inj_pend_chan;
    logic            inj_accept;
    logic            std_accept;
    logic            seq_launch;
    logic            seq_active;
    logic [CH_W-1:0] seq_chan;
    logic            cnv_done;
    logic [CH_W-1:0] cur_chan;
    logic [CH_W-1:0] launch_chan;

    cs_req_capture #(.CH_W(CH_W)) u_capture (
        .clk           (clk),
        .rst_n         (rst_n),
        .std_start     (std_start),
        .std_mode      (std_mode),
        .std_chan      (std_chan),
        .inj_sw_req    (inj_sw_req),
        .inj_hw_trig   (inj_hw_trig),
        .inj_chan      (inj_chan),
        .std_accept    (std_accept),
        .inj_accept    (inj_accept),
        .std_pend      (std_pend),
        .std_pend_chan (std_pend_chan),
        .std_pend_mode (std_pend_mode),
        .inj_pend      (inj_pending),
        .inj_pend_chan (inj_pend_chan)
    );

    cs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .inj_pend   (inj_pending),
        .std_pend   (std_pend),
        .seq_active (seq_active),
        .cnv_done   (cnv_done),
        .inj_accept (inj_accept),
        .std_accept (std_accept),
        .seq_launch (seq_launch),
        .cnv_start  (cnv_start),
        .std_done   (std_done),
        .inj_done   (inj_done)
    );

    cs_sequencer #(.CH_W(CH_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (std_accept),
        .load_chan  (std_pend_chan),
        .load_mode  (std_pend_mode),
        .step       (std_done),
        .keep_going (std_start),
        .seq_active (seq_active),
        .seq_chan   (seq_chan)
    );

    always_comb begin
        if (inj_accept) begin
            launch_chan = inj_pend_chan;
        end else if (std_accept) begin
            launch_chan = std_pend_chan;
        end else begin
            launch_chan = seq_chan;
        end
    end

    cs_conv_stub #(.CH_W(CH_W), .LAT(LAT)) u_stub (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cnv_start),
        .chan     (launch_chan),
        .busy     (cnv_busy),
        .done     (cnv_done),
        .cur_chan (cur_chan)
    );

    assign cnv_chan      = cnv_busy ? cur_chan : launch_chan;
    assign std_done_chan = std_done ? cur_chan : '0;
    assign inj_done_chan = inj_done ? cur_chan : '0;

endmodule

// File: rtl/conv_sched_chk.sv
`timescale 1ns/1ps
module conv_sched_chk #(
    parameter int LAT = 6
) (
    input logic clk,
    input logic rst_n,
    input logic cnv_start,
    input logic cnv_busy,
    input logic std_done,
    input logic inj_done,
    input logic inj_pending
);

    int run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= 0;
        end else if (cnv_start) begin
            run_cnt <= 0;
        end else if (cnv_busy) begin
            run_cnt <= run_cnt + 1;
        end
    end

    // R6
    start_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> cnv_busy);

    // R6
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_busy |-> !cnv_start);

    // R6
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (std_done || inj_done) |-> (run_cnt == LAT - 1));

    // R13
    done_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(std_done && inj_done));

    // R13
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (std_done || inj_done) |=> !(std_done || inj_done));

    // R13
    done_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (std_done || inj_done) |-> cnv_busy);

    // R7
    inj_served_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_pending && !cnv_busy) |-> cnv_start);

endmodule

bind conv_sched conv_sched_chk #(.LAT(LAT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnv_start   (cnv_start),
    .cnv_busy    (cnv_busy),
    .std_done    (std_done),
    .inj_done    (inj_done),
    .inj_pending (inj_pending)
);

// File: tb/conv_sched_bench.sv
`timescale 1ns/1ps
module conv_sched_bench;

    localparam int CH_W = 4;
    localparam int LAT  = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            std_start = 1'b0;
    logic [1:0]      std_mode = 2'b00;
    logic [CH_W-1:0] std_chan = '0;
    logic            inj_sw_req = 1'b0;
    logic            inj_hw_trig = 1'b0;
    logic [CH_W-1:0] inj_chan = '0;
    logic            cnv_start;
    logic [CH_W-1:0] cnv_chan;
    logic            cnv_busy;
    logic            std_done;
    logic [CH_W-1:0] std_done_chan;
    logic            inj_done;
    logic [CH_W-1:0] inj_done_chan;
    logic            inj_pending;

    conv_sched #(.CH_W(CH_W), .LAT(LAT)) u_conv_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .std_start     (std_start),
        .std_mode      (std_mode),
        .std_chan      (std_chan),
        .inj_sw_req    (inj_sw_req),
        .inj_hw_trig   (inj_hw_trig),
        .inj_chan      (inj_chan),
        .cnv_start     (cnv_start),
        .cnv_chan      (cnv_chan),
        .cnv_busy      (cnv_busy),
        .std_done      (std_done),
        .std_done_chan (std_done_chan),
        .inj_done      (inj_done),
        .inj_done_chan (inj_done_chan),
        .inj_pending   (inj_pending)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // behavioural reference state: phase 0 free, 1 standard, 2 injected
    int m_phase, m_left, m_cur;
    int m_inj_req, m_inj_ch, m_std_req, m_std_ch, m_std_mode, m_prev;
    int m_seq, m_seqch, m_base, m_mode;
    int l_kind, l_ch;

    int log_q[$];
    int exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_cur = 0;
            m_inj_req = 0; m_inj_ch = 0; m_std_req = 0; m_std_ch = 0;
            m_std_mode = 0; m_prev = 0; m_seq = 0; m_seqch = 0;
            m_base = 0; m_mode = 0;
        end else begin
            l_kind = 0;
            l_ch = 0;
            if (m_phase == 0) begin
                if (m_inj_req != 0) begin
                    l_kind = 2; l_ch = m_inj_ch; m_inj_req = 0;
                end else if (m_std_req != 0) begin
                    l_kind = 1; m_seq = 1; m_seqch = m_std_ch;
                    m_base = m_std_ch; m_mode = m_std_mode;
                    l_ch = m_std_ch; m_std_req = 0;
                end else if (m_seq != 0) begin
                    l_kind = 1; l_ch = m_seqch;
                end
            end else if (m_left == 1) begin
                if (m_phase == 1) begin
                    if ((m_mode % 2) == 1 && m_seqch > 0) begin
                        m_seqch = m_seqch - 1;
                    end else if (m_mode >= 2 && std_start) begin
                        if ((m_mode % 2) == 1) m_seqch = m_base;
                    end else begin
                        m_seq = 0;
                    end
                end
                m_phase = 0;
            end else begin
                m_left = m_left - 1;
            end
            if (l_kind != 0) begin
                m_phase = l_kind; m_left = LAT; m_cur = l_ch;
            end
            if (inj_sw_req || inj_hw_trig) begin
                m_inj_req = 1; m_inj_ch = int'(inj_chan);
            end
            if (std_start && m_prev == 0) begin
                m_std_req = 1; m_std_ch = int'(std_chan); m_std_mode = int'(std_mode);
            end
            m_prev = std_start ? 1 : 0;
        end
    end

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_start;
            int e_lch;
            e_start = (m_phase == 0) && (m_inj_req != 0 || m_std_req != 0 || m_seq != 0);
            e_lch = (m_inj_req != 0) ? m_inj_ch : ((m_std_req != 0) ? m_std_ch : m_seqch);
            chk(cnv_start == e_start, "R6", "cnv_start", int'(cnv_start), int'(e_start));
            chk(cnv_busy == (m_phase != 0), "R6", "cnv_busy", int'(cnv_busy), int'(m_phase != 0));
            chk(std_done == (m_phase == 1 && m_left == 1), "R13", "std_done",
                int'(std_done), int'(m_phase == 1 && m_left == 1));
            chk(inj_done == (m_phase == 2 && m_left == 1), "R13", "inj_done",
                int'(inj_done), int'(m_phase == 2 && m_left == 1));
            chk(inj_pending == (m_inj_req != 0), "R7", "inj_pending",
                int'(inj_pending), m_inj_req);
            if (e_start) chk(int'(cnv_chan) == e_lch, "R8", "launch chan", int'(cnv_chan), e_lch);
            if (m_phase != 0) chk(int'(cnv_chan) == m_cur, "R13", "busy chan", int'(cnv_chan), m_cur);
            if (std_done) begin
                chk(int'(std_done_chan) == m_cur, "R13", "std_done_chan", int'(std_done_chan), m_cur);
                log_q.push_back(100 + int'(std_done_chan));
            end
            if (inj_done) begin
                chk(int'(inj_done_chan) == m_cur, "R13", "inj_done_chan", int'(inj_done_chan), m_cur);
                log_q.push_back(200 + int'(inj_done_chan));
            end
        end
    end

    // completion-order check: 100+ch for standard, 200+ch for injected
    task automatic check_log(input string req);
        bit ok;
        ok = (log_q.size() == exp_q.size());
        if (ok) begin
            foreach (exp_q[i]) if (log_q[i] != exp_q[i]) ok = 0;
        end
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s done order actual=%p expected=%p", req, log_q, exp_q);
        end
        log_q.delete();
        exp_q.delete();
    endtask

    task automatic wait_quiet();
        int calm = 0;
        for (int n = 0; n < 3000 && calm < 3; n++) begin
            @(negedge clk);
            if (m_phase == 0 && m_inj_req == 0 && m_std_req == 0 && m_seq == 0) calm++;
            else calm = 0;
        end
    endtask

    task automatic start_std(input int mode, input int ch);
        @(negedge clk);
        std_mode  = 2'(mode);
        std_chan  = CH_W'(ch);
        std_start = 1'b1;
    endtask

    task automatic stop_std();
        @(negedge clk);
        std_start = 1'b0;
    endtask

    task automatic pulse_inj(input bit hw, input int ch);
        @(negedge clk);
        inj_chan = CH_W'(ch);
        if (hw) inj_hw_trig = 1'b1; else inj_sw_req = 1'b1;
        @(negedge clk);
        inj_hw_trig = 1'b0;
        inj_sw_req  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!cnv_start && !cnv_busy && !std_done && !inj_done && !inj_pending,
            "R1", "outputs after reset",
            int'({cnv_start, cnv_busy, std_done, inj_done, inj_pending}), 0);

        // R3 single mode, R2 holding start high starts nothing more
        start_std(0, 5);
        wait_quiet();
        repeat (20) @(negedge clk);
        exp_q = '{105};
        check_log("R2");
        stop_std();
        wait_quiet();

        // R4 descending scan
        start_std(1, 3);
        stop_std();
        wait_quiet();
        exp_q = '{103, 102, 101, 100};
        check_log("R4");

        // R5 continuous single channel
        start_std(2, 2);
        repeat (30) @(negedge clk);
        stop_std();
        wait_quiet();
        begin
            bit all_two = 1;
            foreach (log_q[i]) if (log_q[i] != 102) all_two = 0;
            chk(all_two && log_q.size() >= 3, "R5", "continuous repeats",
                log_q.size(), 3);
            log_q.delete();
        end

        // R7 software then hardware injection
        pulse_inj(0, 9);
        chk(inj_pending, "R7", "pending after request", int'(inj_pending), 1);
        wait_quiet();
        chk(!inj_pending, "R7", "pending after service", int'(inj_pending), 0);
        pulse_inj(1, 4);
        wait_quiet();
        exp_q = '{209, 204};
        check_log("R7");

        // R8 coincident injection trigger and standard start
        @(negedge clk);
        std_mode = 2'b01; std_chan = 4'd1; std_start = 1'b1;
        inj_chan = 4'd7; inj_hw_trig = 1'b1;
        @(negedge clk);
        inj_hw_trig = 1'b0;
        std_start = 1'b0;
        wait_quiet();
        exp_q = '{207, 101, 100};
        check_log("R8");

        // R9 standard start while an injection converts
        pulse_inj(0, 3);
        repeat (2) @(negedge clk);
        start_std(0, 6);
        stop_std();
        wait_quiet();
        exp_q = '{203, 106};
        check_log("R9");

        // R10 injection in the middle of a scan
        start_std(1, 3);
        stop_std();
        repeat (2) @(negedge clk);
        pulse_inj(1, 8);
        wait_quiet();
        exp_q = '{103, 208, 102, 101, 100};
        check_log("R10");

        // R11 second trigger lands in the acceptance cycle of the first
        @(negedge clk);
        inj_chan = 4'd1; inj_sw_req = 1'b1;
        @(negedge clk);
        inj_sw_req = 1'b0; inj_chan = 4'd2; inj_hw_trig = 1'b1;
        @(negedge clk);
        inj_hw_trig = 1'b0;
        wait_quiet();
        exp_q = '{201, 202};
        check_log("R11");

        // R12 restart during a running scan
        start_std(1, 3);
        repeat (2) @(negedge clk);
        stop_std();
        start_std(0, 10);
        stop_std();
        wait_quiet();
        exp_q = '{103, 110};
        check_log("R12");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule